// File: doc/BRIEF.md
# Link Self-Test Status Monitor

This block sits on the receive side of a high-speed serial link and runs the bookkeeping for an at-speed self-test. A test is enabled either by a dedicated pin or by a configuration bit. While either is held, the block asserts a request bit that is carried over the return channel so that the far end starts sending its test pattern. The test lasts exactly as long as the enable is held. A pattern checker, which is outside this block, reports each received frame with a strobe and an error flag.

While the test runs, the PASS output stays high. For every errored frame it drops low for the second, clock-low half of one pixel-clock period. When the test ends, PASS turns into a held verdict: high means no frame failed and low means at least one did. The verdict stays until the next test starts or a reset (power-down) occurs.

An 8-bit saturating count of errored frames is exposed as a status value. The reference-clock choice (external pixel clock or internal oscillator) is captured when the test starts. The link-lock indication is passed through as a registered status bit.

Top module: `lbist_status_mon`

## Requirements
- R1: After a synchronous reset, test_req is 0, err_count is 0, ref_src is 0, lock_status is 0, and pass_o is high in both halves of the clock period.
- R2: The test is enabled when bist_pin OR bist_cfg is sampled high at a rising clock edge. test_req becomes 1 after the first edge that samples the enable high, and returns to 0 after the first edge that samples both inputs low.
- R3: ref_src (0 = external pixel clock, 1 = internal oscillator) takes the value of src_sel at the edge where a test starts, that is, where the enable is sampled high while test_req is 0. It then keeps that value for the whole test, whatever src_sel does.
- R4: A frame strobe (frame_vld=1) with frame_err=1, sampled at an edge while test_req is 1, drives pass_o low during the clock-low half of the next cycle. pass_o stays high in the clock-high half of that cycle.
- R5: While test_req is 1, pass_o is high in every half-period that carries no error pulse, even after errors have occurred.
- R6: While test_req is 0, pass_o holds the verdict of the last test: low if that test saw at least one errored frame, high otherwise.
- R7: The start of a new test clears err_count to 0 and sets the held verdict to pass. Both are visible in the cycle after the start edge.
- R8: err_count increments by one for each errored frame sampled while test_req is 1. Error-free frames, and frames sampled while test_req is 0, leave err_count and pass_o unchanged.
- R9: err_count saturates at 255 and does not wrap.
- R10: lock_status equals lock_in as sampled at the previous clock edge.
- R11: A reset in the middle of a test or after a failed test discards the verdict: pass_o goes high and err_count goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset / power-down |
| bist_pin | input | 1 | Test enable from pin |
| bist_cfg | input | 1 | Test enable from configuration bit |
| src_sel | input | 1 | Reference clock choice: 0 external, 1 oscillator |
| frame_vld | input | 1 | One-cycle strobe per received frame |
| frame_err | input | 1 | Frame carried at least one error (valid with frame_vld) |
| lock_in | input | 1 | Link lock from the receiver |
| test_req | output | 1 | Test request toward the transmitter |
| ref_src | output | 1 | Captured reference clock choice |
| pass_o | output | 1 | Pulsed error / held verdict output |
| err_count | output | 8 | Saturating errored-frame count |
| lock_status | output | 1 | Registered lock indication |

## Verification
A stuck or wrongly cleared error flag appears on pass_o in the first idle cycle after a test ends: the held level comes out inverted from what the count implies. A mistimed error pulse is caught within one half-period, because the bench samples pass_o in both clock phases of every cycle. Counter faults such as a wrap, a missed clear at test start or counting outside the test window show on err_count one edge after the offending frame. The bench's own model flags them there.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  localparam int unsigned LBIST_CNT_W = 8;

  typedef enum logic {
    REF_PIXCLK = 1'b0,
    REF_OSC    = 1'b1
  } ref_src_e;

endpackage

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en_pin,
  input  logic     en_cfg,
  input  ref_src_e src_in,
  output logic     active,
  output logic     start,
  output ref_src_e src_q
);

  logic en;

  assign en    = en_pin | en_cfg;
  assign start = en & ~active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      src_q  <= REF_PIXCLK;
    end else begin
      active <= en;
      if (start) src_q <= src_in;
    end
  end

  // R2
  req_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (en_pin || en_cfg) |=> active);

  // R2
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_pin && !en_cfg) |=> !active);

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(src_q));

endmodule

// File: rtl/lbist_err_cnt.sv
module lbist_err_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != MAX)
      cnt <= cnt + 1'b1;
  end

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAX && !clr) |=> cnt == MAX);

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);

endmodule

// File: rtl/lbist_pass_drv.sv
module lbist_pass_drv (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic active,
  input  logic frame_bad,
  output logic level,
  output logic pass_o
);

  logic seen_bad;
  logic pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_bad <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      pulse <= frame_bad;
      if (start)
        seen_bad <= 1'b0;
      else if (frame_bad)
        seen_bad <= 1'b1;
    end
  end

  assign level  = active | ~seen_bad;
  assign pass_o = level & ~(pulse & ~clk);

  // R4
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_bad |=> !pulse);

endmodule

// File: rtl/lbist_status_mon.sv
module lbist_status_mon
  import lbist_pkg::*;
#(
  parameter int unsigned CNT_W = LBIST_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bist_pin,
  input  logic             bist_cfg,
  input  logic             src_sel,
  input  logic             frame_vld,
  input  logic             frame_err,
  input  logic             lock_in,
  output logic             test_req,
  output logic             ref_src,
  output logic             pass_o,
  output logic [CNT_W-1:0] err_count,
  output logic             lock_status
);

  logic     start;
  logic     frame_bad;
  logic     level;
  ref_src_e src_q;

  lbist_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .en_pin (bist_pin),
    .en_cfg (bist_cfg),
    .src_in (ref_src_e'(src_sel)),
    .active (test_req),
    .start  (start),
    .src_q  (src_q)
  );

  assign ref_src   = src_q;
  assign frame_bad = test_req & frame_vld & frame_err;

  lbist_err_cnt #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .inc (frame_bad),
    .cnt (err_count)
  );

  lbist_pass_drv u_pass (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .active    (test_req),
    .frame_bad (frame_bad),
    .level     (level),
    .pass_o    (pass_o)
  );

  always_ff @(posedge clk) begin
    if (rst) lock_status <= 1'b0;
    else     lock_status <= lock_in;
  end

  // R6
  verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!test_req && err_count != '0) |-> !level);

  // R10
  lock_pass_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> lock_status == $past(lock_in));

endmodule

// File: tb/tb_lbist_status_mon.sv
module tb_lbist_status_mon;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, bist_pin, bist_cfg, src_sel, frame_vld, frame_err, lock_in;
  logic test_req, ref_src, pass_o, lock_status;
  logic [7:0] err_count;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  // bench model state
  bit m_act, m_bad, m_pulse, m_ref, m_lock;
  int m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbist_status_mon dut (
    .clk(clk), .rst(rst), .bist_pin(bist_pin), .bist_cfg(bist_cfg),
    .src_sel(src_sel), .frame_vld(frame_vld), .frame_err(frame_err),
    .lock_in(lock_in), .test_req(test_req), .ref_src(ref_src),
    .pass_o(pass_o), .err_count(err_count), .lock_status(lock_status)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_level();
    return (m_act || !m_bad) ? 1 : 0;
  endfunction

  task automatic model_edge();
    bit bad_frame;
    if (rst) begin
      m_act = 0; m_bad = 0; m_pulse = 0; m_ref = 0; m_lock = 0; m_cnt = 0;
    end else begin
      bad_frame = m_act && frame_vld && frame_err;
      m_pulse = bad_frame;
      if ((bist_pin || bist_cfg) && !m_act) begin
        m_cnt = 0; m_bad = 0; m_ref = src_sel;
      end else if (bad_frame) begin
        m_bad = 1;
        if (m_cnt < 255) m_cnt++;
      end
      m_act  = bist_pin || bist_cfg;
      m_lock = lock_in;
    end
  endtask

  task automatic tick(bit p, bit c, bit s, bit v, bit e, bit l, bit r);
    bist_pin = p; bist_cfg = c; src_sel = s;
    frame_vld = v; frame_err = e; lock_in = l; rst = r;
    @(posedge clk);
    model_edge();
    #1;
    chk("R2", int'(test_req), int'(m_act));
    chk("R3", int'(ref_src), int'(m_ref));
    chk("R10", int'(lock_status), int'(m_lock));
    chk(m_cnt == 255 ? "R9" : "R8", int'(err_count), m_cnt);
    chk(m_act ? "R5" : "R6", int'(pass_o), exp_level());
    @(negedge clk);
    #1;
    chk(m_pulse ? "R4" : (m_act ? "R5" : "R6"), int'(pass_o),
        m_pulse ? 0 : exp_level());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit pin_r, cfg_r;
    void'($urandom(32'd5150));
    #2;
    // R1 reset state
    tick(0, 0, 1, 0, 0, 1, 1);
    tick(0, 0, 1, 0, 0, 0, 1);
    chk("R1", int'(test_req), 0);
    chk("R1", int'(err_count), 0);
    chk("R1", int'(pass_o), 1);
    chk("R1", int'(ref_src), 0);

    // pin-only test with three errored frames, oscillator reference
    tick(1, 0, 1, 0, 0, 1, 0);
    for (int i = 0; i < 6; i++) tick(1, 0, 0, 1, i % 2, 1, 0);
    chk("R3", int'(ref_src), 1);
    tick(0, 0, 0, 0, 0, 1, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    chk("R6", int'(pass_o), 0);
    chk("R8", int'(err_count), 3);
    // frames outside the test window are ignored
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 1, 1, 0, 0);
    chk("R8", int'(err_count), 3);
    chk("R6", int'(pass_o), 0);

    // new test via configuration bit clears the verdict and count
    tick(0, 1, 0, 0, 0, 1, 0);
    chk("R7", int'(err_count), 0);
    chk("R7", int'(pass_o), 1);
    for (int i = 0; i < 5; i++) tick(0, 1, 1, 1, 0, 1, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    chk("R6", int'(pass_o), 1);

    // saturation
    tick(1, 1, 0, 0, 0, 1, 0);
    for (int i = 0; i < 300; i++) tick(1, 1, 0, 1, 1, 1, 0);
    chk("R9", int'(err_count), 255);
    tick(0, 0, 0, 0, 0, 1, 0);

    // reset mid-test after errors
    tick(1, 0, 0, 0, 0, 1, 0);
    tick(1, 0, 0, 1, 1, 1, 0);
    tick(1, 0, 0, 0, 0, 1, 1);
    tick(0, 0, 0, 0, 0, 1, 0);
    chk("R11", int'(pass_o), 1);
    chk("R11", int'(err_count), 0);

    // random mix
    pin_r = 0; cfg_r = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) pin_r = ~pin_r;
      if ($urandom_range(0, 59) == 0) cfg_r = ~cfg_r;
      tick(pin_r, cfg_r, 1'($urandom_range(0, 1)),
           $urandom_range(0, 2) == 0, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 299) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule